// File: doc/BRIEF.md
# Word-to-byte output adapter FIFO

This block is a single-clock FIFO that stores 18-bit words and hands them to its reader either as whole words or as pairs of 9-bit bytes. The output width and the order of the two bytes inside a word are taken from two select pins while the active-low reset is held. The values are frozen when reset is released and stay fixed until the next reset.

The read side uses show-ahead presentation. Whenever a complete output unit is available it is visible on the data output, and a read strobe consumes it. The empty flag and the availability count are expressed in the configured output unit: words in word mode, bytes in byte mode. In byte mode a storage slot is given back to the writer only after both of its bytes have been consumed. A read strobe with nothing to deliver is dropped, and so is a write strobe while the storage is full.

Top module: `fifo_bm_out`

## Requirements
- R1: `out_byte_i` and `little_i` are captured while `rst_ni` is low. Changing them after reset release has no effect on ordering, width or counts until the next reset.
- R2: With `out_byte_i`=0 at reset (word mode), words come out whole on `rd_data_o[17:0]` in write order, one per accepted read. `little_i` has no effect in this mode.
- R3: With `out_byte_i`=1 and `little_i`=0 at reset (big-endian byte mode), each word yields bits [17:9] first and bits [8:0] second. Each byte appears on `rd_data_o[8:0]`, and `rd_data_o[17:9]` is zero.
- R4: With `out_byte_i`=1 and `little_i`=1 at reset (little-endian byte mode), each word yields bits [8:0] first and bits [17:9] second, using the same output placement as R3.
- R5: In byte mode a stored word keeps its slot until its second byte is read. `full_o` stays high after only the first byte of the oldest word of a full FIFO has been read.
- R6: `avail_o` equals the number of complete output units held: stored words in word mode, and twice the stored words minus one while a word is half consumed in byte mode. `empty_o` is high exactly when `avail_o` is zero.
- R7: A read strobe while `empty_o` is high is ignored. The count stays zero, and later data is unaffected.
- R8: A write strobe while `full_o` is high is ignored. The count is unchanged, and the stored words are read out unaltered.
- R9: After reset `empty_o`=1, `full_o`=0, `avail_o`=0 and `rd_data_o`=0. `rd_data_o` is zero whenever `empty_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; configuration is captured while low |
| out_byte_i | input | 1 | Output width select: 1 selects bytes, 0 selects words |
| little_i | input | 1 | Byte order select: 1 sends the low byte first, 0 sends the high byte first |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | WORD_W | Word to store |
| full_o | output | 1 | No free storage slot |
| rd_en_i | input | 1 | Read strobe; consumes the unit currently shown |
| rd_data_o | output | WORD_W | Current output unit; a byte is placed in the low half |
| empty_o | output | 1 | No complete output unit available |
| avail_o | output | $clog2(2*DEPTH+1) | Complete output units held |

## Verification
The bench builds the block with DEPTH=4 and the default 18-bit word. At this depth the FIFO fills after four writes and drains after at most eight reads, so all four reset configurations can be swept. Each sweep covers full and empty boundaries, over-full writes, reads on an empty FIFO, the half-consumed full slot, and a streaming phase where a write and a read fall on the same clock edge.

// File: rtl/fifo_bm_pkg.sv
package fifo_bm_pkg;
  typedef struct packed {
    logic byte_out;
    logic little;
  } bm_cfg_t;
endpackage

// File: rtl/fifo_bm_cfg.sv
module fifo_bm_cfg
  import fifo_bm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  bm_cfg_t pins_i,
  output bm_cfg_t cfg_o
);
  logic run_q;

  // configuration loads asynchronously while reset is held, then holds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= pins_i;
      run_q <= 1'b0;
    end else begin
      cfg_o <= cfg_o;
      run_q <= 1'b1;
    end
  end

  p_cfg_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_q)
    $stable(cfg_o));
endmodule

// File: rtl/fifo_bm_store.sv
module fifo_bm_store #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  assign head_o = mem_q[rd_ptr_q];
  assign full_o = (count_o == CNT_W'(DEPTH));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_o != CNT_W'(DEPTH)));
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (count_o != '0));
  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
endmodule

// File: rtl/fifo_bm_unpack.sv
module fifo_bm_unpack
  import fifo_bm_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bm_cfg_t           cfg_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              rd_en_i,
  output logic              pop_o,
  output logic [WORD_W-1:0] data_o,
  output logic [AV_W-1:0]   avail_o,
  output logic              empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AV_W  = $clog2(2 * DEPTH + 1);
  localparam int HALF  = WORD_W / 2;

  logic phase_q;  // high: first byte of head word already delivered
  logic take;
  logic sel_hi;
  logic [HALF-1:0] byte_sel;

  assign avail_o = cfg_i.byte_out ? (AV_W'({count_i, 1'b0}) - AV_W'(phase_q))
                                  : AV_W'(count_i);
  assign empty_o = (avail_o == '0);
  assign take    = rd_en_i && !empty_o;
  assign pop_o   = take && (!cfg_i.byte_out || phase_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     phase_q <= 1'b0;
    else if (take && cfg_i.byte_out) phase_q <= !phase_q;
  end

  assign sel_hi   = phase_q ^ !cfg_i.little;
  assign byte_sel = sel_hi ? head_i[WORD_W-1 -: HALF] : head_i[HALF-1:0];

  always_comb begin
    if (empty_o)               data_o = '0;
    else if (cfg_i.byte_out)   data_o = WORD_W'(byte_sel);
    else                       data_o = head_i;
  end

  p_word_no_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.byte_out |-> !phase_q);
  p_half_word_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q |-> (count_i != '0));
  p_byte_pop_second_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && cfg_i.byte_out) |-> phase_q);
endmodule

// File: rtl/fifo_bm_out.sv
module fifo_bm_out
  import fifo_bm_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AV_W  = $clog2(2 * DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              out_byte_i,
  input  logic              little_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              full_o,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic [AV_W-1:0]   avail_o
);
  bm_cfg_t           pins, cfg;
  logic              push, pop;
  logic [WORD_W-1:0] head;
  logic [CNT_W-1:0]  count;

  assign pins = '{byte_out: out_byte_i, little: little_i};
  assign push = wr_en_i && !full_o;

  fifo_bm_cfg u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins), .cfg_o(cfg)
  );

  fifo_bm_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .wdata_i(wr_data_i),
    .pop_i(pop), .head_o(head), .count_o(count), .full_o(full_o)
  );

  fifo_bm_unpack #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_unpack (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg), .head_i(head),
    .count_i(count), .rd_en_i(rd_en_i), .pop_o(pop), .data_o(rd_data_o),
    .avail_o(avail_o), .empty_o(empty_o)
  );

  p_empty_read_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o && !wr_en_i) |=> (avail_o == '0));
  p_empty_zero_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_data_o == '0));
endmodule

// File: tb/fifo_bm_out_bench.sv
module fifo_bm_out_bench;
  localparam int W  = 18;
  localparam int D  = 4;
  localparam int AW = $clog2(2 * D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic out_byte = 1'b0, little = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic full, empty;
  logic [W-1:0] rd_data;
  logic [AW-1:0] avail;

  int n_tests = 0, n_fail = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  fifo_bm_out #(.WORD_W(W), .DEPTH(D)) u_fifo_bm_out (
    .clk_i(clk), .rst_ni(rst_n), .out_byte_i(out_byte), .little_i(little),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .full_o(full), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .empty_o(empty), .avail_o(avail)
  );

  // bench model
  logic [W-1:0] q_words [$];
  int  m_phase;
  logic m_byte, m_little;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_avail();
    return m_byte ? 2 * q_words.size() - m_phase : q_words.size();
  endfunction

  function automatic int exp_data();
    logic [W-1:0] w;
    logic hi;
    if (q_words.size() == 0) return 0;
    w = q_words[0];
    if (!m_byte) return int'(w);
    hi = (m_phase == 0) ? !m_little : m_little;
    return hi ? int'(w[17:9]) : int'(w[8:0]);
  endfunction

  task automatic check_out(string req);
    chk(req, "avail", int'(avail), exp_avail());
    chk(req, "empty", int'(empty), int'(exp_avail() == 0));
    chk(req, "full", int'(full), int'(q_words.size() == D));
    chk(req, "data", int'(rd_data), exp_data());
  endtask

  // one cycle with given strobes; model updated after the edge
  task automatic cycle(logic we, logic [W-1:0] d, logic re);
    bit can_rd, can_wr;
    can_rd = re && (exp_avail() != 0);
    can_wr = we && (q_words.size() != D);
    wr_en = we; wr_data = d; rd_en = re;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (can_rd) begin
      if (m_byte && m_phase == 0) m_phase = 1;
      else begin
        m_phase = 0;
        void'(q_words.pop_front());
      end
    end
    if (can_wr) q_words.push_back(d);
  endtask

  function automatic logic [W-1:0] pat(int cfg, int k);
    return W'((k * 40503 + cfg * 7919 + 12345) & 18'h3FFFF);
  endfunction

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    for (int cfg = 0; cfg < 4; cfg++) begin
      m_byte = cfg[1]; m_little = cfg[0]; m_phase = 0;
      q_words.delete();
      @(negedge clk);
      rst_n = 1'b0; out_byte = m_byte; little = m_little;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R9");
      // flip pins: must not matter (R1)
      out_byte = !m_byte; little = !m_little;
      // read on empty (R7)
      cycle(1'b0, '0, 1'b1);
      cycle(1'b0, '0, 1'b1);
      check_out("R7");
      // fill, checking count in output units (R6)
      for (int k = 0; k < D; k++) begin
        cycle(1'b1, pat(cfg, k), 1'b0);
        check_out("R6");
      end
      // write while full (R8)
      cycle(1'b1, 18'h3FFFF, 1'b0);
      check_out("R8");
      if (m_byte) begin
        cycle(1'b0, '0, 1'b1);
        chk("R5", "full_after_first_byte", int'(full), 1);
        cycle(1'b1, 18'h15555, 1'b0);
        check_out("R5");
      end
      // drain with order checks (R2/R3/R4, R1)
      while (exp_avail() != 0) begin
        check_out(!m_byte ? "R2" : (m_little ? "R4" : "R3"));
        cycle(1'b0, '0, 1'b1);
      end
      check_out("R1");
      // streaming: simultaneous write and read
      cycle(1'b1, pat(cfg, 10), 1'b0);
      for (int k = 11; k < 20; k++) begin
        cycle(1'b1, pat(cfg, k), 1'b1);
        check_out(m_byte ? (m_little ? "R4" : "R3") : "R2");
      end
      while (exp_avail() != 0) begin
        cycle(1'b0, '0, 1'b1);
        check_out("R6");
      end
      cycle(1'b0, '0, 1'b1);
      check_out("R7");
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule